// File: doc/BRIEF.md
# Cascaded 32-Bit Counter with Coherent Two-Channel Capture

This block holds a 32-bit count split into a lower and an upper 16-bit half. The lower half advances on each cycle in which the tick input is high and counting is enabled. The upper half advances by one each time the lower half wraps from all ones to zero. Each of two capture channels keeps a pair of 16-bit capture registers, one for each half. External capture pins are brought into the clock domain through a two-flop synchronizer, followed by a rising-edge detector.

A control bit picks one of two capture modes. In split mode, each half of a channel is latched from its own pin. Because the upper half is then taken before the carry of that cycle, a capture at the wrap point can record a stale upper half. In joined mode, the channel's lower pin alone latches both halves in one cycle, and both hold the post-carry value.

Software reaches the block through a small register port. This port holds a control word, sticky capture flags that are cleared by writing 1, counter load registers, and read-back of the capture registers.

Top module: `cascade_capture_timer`

## Requirements
- R1: While counting is enabled and tick is high, the lower half increments by one per cycle. The upper half increments only in the cycle in which the lower half goes from 0xFFFF to 0x0000. Both halves wrap to zero.
- R2: When CTRL bit 0 (count enable) is 0, or tick is low, neither half changes unless it is loaded.
- R3: A capture pin goes through two synchronizer flops and a rising-edge detector. A pin first seen high at clock edge k captures at edge k+2. The captured value is the counter value after the update at edge k+2. A pin held high captures only once.
- R4: Split mode is selected by CTRL bit 1 = 0. A channel's lower pin loads its lower capture register with the post-update lower half. Its upper pin loads its upper capture register with the upper half as it stood before that cycle's carry.
- R5: Joined mode is selected by CTRL bit 1 = 1. A channel's lower pin loads both of its capture registers with the post-update 32-bit value in the same cycle.
- R6: In joined mode the upper capture pins have no effect.
- R7: STATUS bit c (bit 0 = channel A, bit 1 = channel B) is set by any capture on channel c. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: A synchronous active-high reset clears both halves, all capture registers, all flags and CTRL.
- R9: The register map is: 0 CTRL, 1 STATUS, 2 count low, 3 count high, 4 A low capture, 5 A high capture, 6 B low capture, 7 B high capture. Writing address 2 or 3 loads that half of the counter. rdata shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse for the lower half |
| cap_lo_pin | input | 2 | Asynchronous lower-half capture pin per channel (bit 0 = A) |
| cap_hi_pin | input | 2 | Asynchronous upper-half capture pin per channel (bit 0 = A) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |

## Verification
A capture pin raised before edge k latches at edge k+2. The bench therefore raises tick for the single cycle that ends at edge k+2 and expects the captured value to include that increment and any carry. Register writes take effect at the edge that follows the strobe. Reads return data one edge after the address is set. Every check is sampled on the falling edge after that result edge, and the capture registers are read only after the pins have returned low and tick is idle, so that the values are stable.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_STATUS = 1;
  localparam int unsigned A_CNT_LO = 2;
  localparam int unsigned A_CNT_HI = 3;
  localparam int unsigned A_CAP0   = 4;
  localparam int unsigned CTRL_EN  = 0;
  localparam int unsigned CTRL_SIM = 1;
endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  output logic pulse
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin_in};
  end

  assign pulse = sh[STAGES-1] & ~sh[STAGES];

  // R3: a pulse means the pin was high STAGES edges earlier
  a_r3_sync_delay: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(pin_in, STAGES));
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              tick,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [HALF_W-1:0] ld_data,
  output logic [HALF_W-1:0] lo_q,
  output logic [HALF_W-1:0] hi_q,
  output logic [HALF_W-1:0] lo_nxt,
  output logic [HALF_W-1:0] hi_nxt
);
  localparam logic [HALF_W-1:0] ALL_ONES = '1;
  logic step;

  assign step = cnt_en & tick;

  always_comb begin
    lo_nxt = lo_q;
    hi_nxt = hi_q;
    if (step) begin
      lo_nxt = lo_q + 1'b1;
      if (lo_q == ALL_ONES) hi_nxt = hi_q + 1'b1;
    end
    if (ld_lo) lo_nxt = ld_data;
    if (ld_hi) hi_nxt = ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nxt;
      hi_q <= hi_nxt;
    end
  end

  a_r1_carry: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && tick && !ld_lo && !ld_hi && lo_q == ALL_ONES)
      |=> (lo_q == '0 && hi_q == HALF_W'($past(hi_q) + 1'b1)));

  a_r1_no_carry: assert property (@(posedge clk) disable iff (rst)
    (!ld_hi && lo_q != ALL_ONES) |=> $stable(hi_q));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!(cnt_en && tick) && !ld_lo && !ld_hi) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/cct_capture_chan.sv
module cct_capture_chan #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sim_mode,
  input  logic              lo_pulse,
  input  logic              hi_pulse,
  input  logic [HALF_W-1:0] cnt_hi_q,
  input  logic [HALF_W-1:0] cnt_hi_nxt,
  input  logic [HALF_W-1:0] cnt_lo_nxt,
  output logic [HALF_W-1:0] cap_lo,
  output logic [HALF_W-1:0] cap_hi,
  output logic              capt
);
  assign capt = lo_pulse | (~sim_mode & hi_pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo <= '0;
      cap_hi <= '0;
    end else begin
      if (lo_pulse) cap_lo <= cnt_lo_nxt;
      if (sim_mode && lo_pulse)       cap_hi <= cnt_hi_nxt;
      else if (!sim_mode && hi_pulse) cap_hi <= cnt_hi_q;
    end
  end

  // R6: upper pin ignored in joined mode
  a_r6_sim_hi_ignored: assert property (@(posedge clk) disable iff (rst)
    (sim_mode && !lo_pulse) |=> $stable(cap_hi));
endmodule

// File: rtl/cascade_capture_timer.sv
module cascade_capture_timer #(
  parameter int HALF_W      = 16,
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(cct_pkg::A_CAP0 + 2 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NUM_CH-1:0] cap_lo_pin,
  input  logic [NUM_CH-1:0] cap_hi_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] rdata
);
  import cct_pkg::*;

  logic              ctrl_en, ctrl_sim;
  logic [NUM_CH-1:0] flags, lo_pulse, hi_pulse, capt;
  logic [HALF_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt, rd_mux;
  logic [HALF_W-1:0] cap_lo [NUM_CH];
  logic [HALF_W-1:0] cap_hi [NUM_CH];
  logic              wr_ctrl, wr_stat, ld_lo, ld_hi;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
  assign wr_stat = wr_en && (addr == ADDR_W'(A_STATUS));
  assign ld_lo   = wr_en && (addr == ADDR_W'(A_CNT_LO));
  assign ld_hi   = wr_en && (addr == ADDR_W'(A_CNT_HI));

  cct_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(ctrl_en), .tick(tick),
    .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(wdata),
    .lo_q(lo_q), .hi_q(hi_q), .lo_nxt(lo_nxt), .hi_nxt(hi_nxt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_lo (
      .clk(clk), .rst(rst), .pin_in(cap_lo_pin[c]), .pulse(lo_pulse[c]));
    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_hi (
      .clk(clk), .rst(rst), .pin_in(cap_hi_pin[c]), .pulse(hi_pulse[c]));
    cct_capture_chan #(.HALF_W(HALF_W)) u_chan (
      .clk(clk), .rst(rst), .sim_mode(ctrl_sim),
      .lo_pulse(lo_pulse[c]), .hi_pulse(hi_pulse[c]),
      .cnt_hi_q(hi_q), .cnt_hi_nxt(hi_nxt), .cnt_lo_nxt(lo_nxt),
      .cap_lo(cap_lo[c]), .cap_hi(cap_hi[c]), .capt(capt[c]));

    // R5: joined capture equals the counter registers after the same edge
    a_r5_coherent: assert property (@(posedge clk) disable iff (rst)
      (ctrl_sim && lo_pulse[c]) |=> (cap_lo[c] == lo_q && cap_hi[c] == hi_q));
    // R4: split lower capture equals the post-update lower half
    a_r4_split_lo: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_sim && lo_pulse[c]) |=> (cap_lo[c] == lo_q));
    // R7: any capture leaves the flag set
    a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
      capt[c] |=> flags[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en  <= 1'b0;
      ctrl_sim <= 1'b0;
      flags    <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= wdata[CTRL_EN];
        ctrl_sim <= wdata[CTRL_SIM];
      end
      flags <= (flags & ~(wr_stat ? wdata[NUM_CH-1:0] : '0)) | capt;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_W'(A_CTRL):   rd_mux = HALF_W'({ctrl_sim, ctrl_en});
      ADDR_W'(A_STATUS): rd_mux = HALF_W'(flags);
      ADDR_W'(A_CNT_LO): rd_mux = lo_q;
      ADDR_W'(A_CNT_HI): rd_mux = hi_q;
      default: ;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(A_CAP0 + 2 * c))     rd_mux = cap_lo[c];
      if (addr == ADDR_W'(A_CAP0 + 2 * c + 1)) rd_mux = cap_hi[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: tb/test_cascade_capture_timer.sv
`timescale 1ns/1ps
module test_cascade_capture_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [1:0]  cap_lo_pin = '0;
  logic [1:0]  cap_hi_pin = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  cascade_capture_timer i_cascade_capture_timer (
    .clk(clk), .rst(rst), .tick(tick), .cap_lo_pin(cap_lo_pin),
    .cap_hi_pin(cap_hi_pin), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata));

  typedef struct packed {
    logic        sim;
    logic [15:0] hi0;
    logic [15:0] lo0;
    logic        tk;
    logic [3:0]  pins;   // {B hi, B lo, A hi, A lo}
    logic [1:0]  flg;
    logic [15:0] alo, ahi, blo, bhi;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'hFFF0, 16'hFFFF, 1'b1, 4'b0011, 2'b01, 16'h0000, 16'hFFF0, 16'h0000, 16'h0000},
    '{1'b1, 16'hFFF0, 16'hFFFF, 1'b1, 4'b0001, 2'b01, 16'h0000, 16'hFFF1, 16'h0000, 16'h0000},
    '{1'b1, 16'h1234, 16'h5678, 1'b0, 4'b0100, 2'b10, 16'h0000, 16'h0000, 16'h5678, 16'h1234},
    '{1'b1, 16'h0000, 16'h0010, 1'b1, 4'b0010, 2'b00, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{1'b0, 16'h0002, 16'h0003, 1'b1, 4'b1000, 2'b10, 16'h0000, 16'h0000, 16'h0000, 16'h0002},
    '{1'b0, 16'hABCD, 16'h7FFF, 1'b1, 4'b0101, 2'b11, 16'h8000, 16'h0000, 16'h8000, 16'h0000},
    '{1'b1, 16'h0001, 16'h0002, 1'b1, 4'b0101, 2'b11, 16'h0003, 16'h0001, 16'h0003, 16'h0001},
    '{1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 4'b0011, 2'b01, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000},
    '{1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 4'b0001, 2'b01, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got cycle %0d exp completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic run_vec(input vec_t v);
    do_reset();
    wr(3'd3, v.hi0);
    wr(3'd2, v.lo0);
    wr(3'd0, {14'd0, v.sim, 1'b1});
    cap_lo_pin = {v.pins[2], v.pins[0]};
    cap_hi_pin = {v.pins[3], v.pins[1]};
    @(negedge clk);            // after edge k
    @(negedge clk);            // after edge k+1
    tick = v.tk;
    @(negedge clk);            // after edge k+2: capture done
    tick = 1'b0;
    cap_lo_pin = '0;
    cap_hi_pin = '0;
    repeat (4) @(negedge clk);
  endtask

  logic [15:0] v;

  initial begin
    // R8: reset state
    do_reset();
    for (int a = 0; a < 8; a++) expect_reg("R8 reset value", 3'(a), 16'h0000);

    // R4 R5 R6 R7 R3: vector table
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i]);
      expect_reg("R7 flags",       3'd1, {14'd0, VECS[i].flg});
      expect_reg("R4/R5 A low",    3'd4, VECS[i].alo);
      expect_reg("R4/R5 A high",   3'd5, VECS[i].ahi);
      expect_reg("R4/R5/R6 B low", 3'd6, VECS[i].blo);
      expect_reg("R4/R5/R6 B high",3'd7, VECS[i].bhi);
    end

    // R1 R9: carry across three ticks, load through the register port
    do_reset();
    wr(3'd3, 16'h0007);
    wr(3'd2, 16'hFFFE);
    expect_reg("R9 load low", 3'd2, 16'hFFFE);
    wr(3'd0, 16'h0001);
    expect_reg("R9 ctrl readback", 3'd0, 16'h0001);
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    expect_reg("R1 low after wrap", 3'd2, 16'h0001);
    expect_reg("R1 high after carry", 3'd3, 16'h0008);

    // R2: enable off with tick, then enable on without tick
    wr(3'd0, 16'h0000);
    @(negedge clk); tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    expect_reg("R2 disabled low", 3'd2, 16'h0001);
    wr(3'd0, 16'h0001);
    repeat (5) @(negedge clk);
    expect_reg("R2 no tick low", 3'd2, 16'h0001);
    expect_reg("R2 no tick high", 3'd3, 16'h0008);

    // R3: held pin captures once, a new edge captures again
    do_reset();
    wr(3'd2, 16'h0100);
    wr(3'd0, 16'h0001);
    cap_lo_pin = 2'b01;
    repeat (4) @(negedge clk);
    tick = 1'b1;
    repeat (6) @(negedge clk);
    tick = 1'b0;
    expect_reg("R3 held pin single capture", 3'd4, 16'h0100);
    cap_lo_pin = 2'b00;
    repeat (3) @(negedge clk);
    cap_lo_pin = 2'b01;
    repeat (4) @(negedge clk);
    cap_lo_pin = 2'b00;
    expect_reg("R3 second edge captures", 3'd4, 16'h0106);

    // R7: write 0 keeps flag, write 1 clears it
    wr(3'd1, 16'h0000);
    expect_reg("R7 write 0 keeps flag", 3'd1, 16'h0001);
    wr(3'd1, 16'h0001);
    expect_reg("R7 write 1 clears flag", 3'd1, 16'h0000);

    // R8: reset from a dirty state
    run_vec(VECS[6]);
    do_reset();
    for (int a = 0; a < 8; a++) expect_reg("R8 reset clears state", 3'(a), 16'h0000);

    rd(3'd0, v);
    summary();
    $finish;
  end
endmodule